// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Day Count and Alarm

This block keeps wall-clock time for a chip. A one-second enable pulse from an external prescaler advances a seconds field, which carries into minutes, then hours, then a binary day counter. Seconds, minutes and hours are kept as packed BCD, so software reads them without conversion. The date is a plain count of elapsed days, and software works out any year, month or leap day from that count.

Software reaches the block through a byte-wide register port: an address, write data, a write strobe and combinational read data. This port carries single register accesses, not a data stream, so it has no valid/ready handshake and no back-pressure. A write that arrives in the cycle when the counters advance is held for one cycle and then applied. A comparator matches the current minute, hour and day against alarm fields that software selects. On a match it sets a sticky flag, which can drive an interrupt line.

Top module: `bcd_day_calendar`

## Requirements
- R1: After reset every time, day and alarm field reads 0x00, the control register reads 0x00 and `alarm_irq` is low.
- R2: Register map: 0x14 control, 0x15 seconds, 0x16 minutes, 0x17 hours, 0x18 day bits 7:0, 0x19 day bits 14:8 (read bit 7 is 0), 0x1A alarm minutes, 0x1B alarm hours, 0x1C/0x1D alarm day low/high. Any other address reads 0x00 and ignores writes.
- R3: Control register bits: 0 counting enable, 1 interrupt enable, 2 alarm flag, 3 minute match enable, 4 hour match enable, 5 day match enable, 7 busy (read-only). Bit 6 reads 0.
- R4: A tick advances seconds by one in BCD (0x09 goes to 0x10). Seconds wrap from 0x59 to 0x00 and carry into minutes.
- R5: Minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00 and carry into the day count.
- R6: The day count is 15-bit binary. A carry out of bit 7 reaches the high byte, and the count wraps from 0x7FFF to 0.
- R7: A tick while the enable bit is clear changes no field, and busy stays 0.
- R8: Busy reads 1 exactly in the cycle when a tick arrives while counting is enabled.
- R9: A write in a busy cycle is not applied in that cycle. It takes effect one cycle later, after the tick's update, so the written value replaces the value the tick produced.
- R10: The alarm flag sets on a tick that wraps seconds to 0x00, when at least one match enable is set and every enabled field has just become equal to its alarm field. Seconds are never compared.
- R11: A disabled field does not take part in the match.
- R12: If the enabled fields were already equal before the minute rollover, the flag does not set again.
- R13: Writing the control register with bit 2 = 1 clears the flag. Writing bit 2 = 0 leaves it unchanged.
- R14: `alarm_irq` equals the flag ANDed with control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second advance enable, one cycle wide |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt, level |

## Verification
The embedded properties assume that `tick` pulses are at least two cycles apart, so that a held write never has to share a cycle with a second tick. They also assume that software does not issue two writes back to back while a held write is still pending. The bench spaces ticks two cycles apart and issues at most one write inside a tick cycle, followed by an idle cycle. All alarm cases begin from time values that software has just written, so the flag can only set through a minute rollover and never through a write.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam logic [7:0] ADR_CTL  = 8'h14;
  localparam logic [7:0] ADR_SEC  = 8'h15;
  localparam logic [7:0] ADR_MIN  = 8'h16;
  localparam logic [7:0] ADR_HR   = 8'h17;
  localparam logic [7:0] ADR_DLO  = 8'h18;
  localparam logic [7:0] ADR_DHI  = 8'h19;
  localparam logic [7:0] ADR_AMIN = 8'h1A;
  localparam logic [7:0] ADR_AHR  = 8'h1B;
  localparam logic [7:0] ADR_ADLO = 8'h1C;
  localparam logic [7:0] ADR_ADHI = 8'h1D;

  localparam int CB_RUN  = 0;
  localparam int CB_IEN  = 1;
  localparam int CB_FLG  = 2;
  localparam int CB_MEN  = 3;
  localparam int CB_HEN  = 4;
  localparam int CB_DEN  = 5;
  localparam int CB_BUSY = 7;

  localparam int NUM_BCD = 3;

  typedef struct packed {
    logic den;
    logic hen;
    logic men;
    logic ien;
    logic run;
  } cal_ctl_t;

endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
  parameter logic [7:0] LIMIT = 8'h59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] val,
  output logic [7:0] nxt,
  output logic       at_lim
);

  assign at_lim = (val == LIMIT);

  always_comb begin
    nxt = val;
    if (ld) begin
      nxt = ld_val;
    end else if (inc) begin
      if (at_lim)                nxt = 8'h00;
      else if (val[3:0] == 4'd9) nxt = {val[7:4] + 4'd1, 4'h0};
      else                       nxt = {val[7:4], val[3:0] + 4'd1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= 8'h00;
    else        val <= nxt;
  end

  // R4 / R5: a field at its limit returns to zero on the advance
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && val == LIMIT) |=> (val == 8'h00));

  // R7: with no advance and no load the field keeps its value
  a_r7_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(val));

endmodule

// File: rtl/cal_day_count.sv
module cal_day_count #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [7:0]       ld_byte,
  output logic [DAY_W-1:0] val,
  output logic [DAY_W-1:0] nxt
);

  localparam int HI_W = DAY_W - 8;

  always_comb begin
    nxt = val;
    if (ld_lo)      nxt = {val[DAY_W-1:8], ld_byte};
    else if (ld_hi) nxt = {ld_byte[HI_W-1:0], val[7:0]};
    else if (inc)   nxt = val + {{(DAY_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else        val <= nxt;
  end

  // R6: full count wraps to zero
  a_r6_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_lo && !ld_hi && (&val)) |=> (val == '0));

  // R7: no advance, no load, no change
  a_r7_day_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld_lo && !ld_hi) |=> $stable(val));

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_min,
  input  logic             ld_hr,
  input  logic             ld_dlo,
  input  logic             ld_dhi,
  input  logic [7:0]       ld_byte,
  input  logic             men,
  input  logic             hen,
  input  logic             den,
  input  logic [7:0]       cur_min,
  input  logic [7:0]       cur_hr,
  input  logic [DAY_W-1:0] cur_day,
  input  logic [7:0]       nxt_min,
  input  logic [7:0]       nxt_hr,
  input  logic [DAY_W-1:0] nxt_day,
  input  logic             roll,
  input  logic             clr,
  output logic [7:0]       al_min,
  output logic [7:0]       al_hr,
  output logic [DAY_W-1:0] al_day,
  output logic             flag
);

  localparam int HI_W = DAY_W - 8;

  logic any_en, hit_now, hit_nxt, set_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_min <= 8'h00;
      al_hr  <= 8'h00;
      al_day <= '0;
    end else begin
      if (ld_min) al_min <= ld_byte;
      if (ld_hr)  al_hr  <= ld_byte;
      if (ld_dlo) al_day[7:0] <= ld_byte;
      if (ld_dhi) al_day[DAY_W-1:8] <= ld_byte[HI_W-1:0];
    end
  end

  assign any_en  = men | hen | den;
  assign hit_now = (!men || cur_min == al_min) &&
                   (!hen || cur_hr  == al_hr)  &&
                   (!den || cur_day == al_day);
  assign hit_nxt = (!men || nxt_min == al_min) &&
                   (!hen || nxt_hr  == al_hr)  &&
                   (!den || nxt_day == al_day);
  assign set_flag = roll && any_en && hit_nxt && !hit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_flag) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  // R10: the flag only rises on a seconds rollover
  a_r10_rise_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(roll));

  // R12: a match that already held before the rollover sets nothing new
  a_r12_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && hit_now && !clr) |=> (flag == $past(flag)));

  // R13: without a clear request the flag is sticky
  a_r13_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

endmodule

// File: rtl/bcd_day_calendar.sv
module bcd_day_calendar #(
  parameter int DAY_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  output logic       alarm_irq
);
  import cal_pkg::*;

  localparam int HI_W = DAY_W - 8;

  cal_ctl_t   ctl;
  logic       busy;
  logic       flag;

  // write hold stage
  logic       held_v;
  logic [7:0] held_a, held_d;
  logic       app_v;
  logic [7:0] app_a, app_d;

  // counter fields: 0 seconds, 1 minutes, 2 hours
  logic [7:0]       f_val [NUM_BCD];
  logic [7:0]       f_nxt [NUM_BCD];
  logic             f_lim [NUM_BCD];
  logic [NUM_BCD:0] carry;
  logic [DAY_W-1:0] day_val, day_nxt;
  logic [7:0]       al_min, al_hr;
  logic [DAY_W-1:0] al_day;
  logic [7:0]       day_hi_rd, al_hi_rd;

  assign busy = tick & ctl.run;

  // apply held write first; a live write is applied only outside busy
  assign app_v = !busy && (held_v || reg_we);
  assign app_a = held_v ? held_a : reg_addr;
  assign app_d = held_v ? held_d : reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      held_a <= 8'h00;
      held_d <= 8'h00;
    end else if (reg_we && (busy || held_v)) begin
      held_v <= 1'b1;
      held_a <= reg_addr;
      held_d <= reg_wdata;
    end else if (!busy) begin
      held_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (app_v && app_a == ADR_CTL) begin
      ctl.run <= app_d[CB_RUN];
      ctl.ien <= app_d[CB_IEN];
      ctl.men <= app_d[CB_MEN];
      ctl.hen <= app_d[CB_HEN];
      ctl.den <= app_d[CB_DEN];
    end
  end

  assign carry[0] = busy;

  for (genvar g = 0; g < NUM_BCD; g++) begin : g_fld
    localparam logic [7:0] LIM = (g == NUM_BCD - 1) ? 8'h23 : 8'h59;
    logic ld;
    assign ld = app_v && (app_a == ADR_SEC + 8'(g));
    cal_bcd_field #(.LIMIT(LIM)) u_fld (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (carry[g]),
      .ld     (ld),
      .ld_val (app_d),
      .val    (f_val[g]),
      .nxt    (f_nxt[g]),
      .at_lim (f_lim[g])
    );
    assign carry[g+1] = carry[g] && f_lim[g];
  end

  cal_day_count #(.DAY_W(DAY_W)) u_day (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (carry[NUM_BCD]),
    .ld_lo   (app_v && app_a == ADR_DLO),
    .ld_hi   (app_v && app_a == ADR_DHI),
    .ld_byte (app_d),
    .val     (day_val),
    .nxt     (day_nxt)
  );

  cal_alarm #(.DAY_W(DAY_W)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_min  (app_v && app_a == ADR_AMIN),
    .ld_hr   (app_v && app_a == ADR_AHR),
    .ld_dlo  (app_v && app_a == ADR_ADLO),
    .ld_dhi  (app_v && app_a == ADR_ADHI),
    .ld_byte (app_d),
    .men     (ctl.men),
    .hen     (ctl.hen),
    .den     (ctl.den),
    .cur_min (f_val[1]),
    .cur_hr  (f_val[2]),
    .cur_day (day_val),
    .nxt_min (f_nxt[1]),
    .nxt_hr  (f_nxt[2]),
    .nxt_day (day_nxt),
    .roll    (carry[1]),
    .clr     (app_v && app_a == ADR_CTL && app_d[CB_FLG]),
    .al_min  (al_min),
    .al_hr   (al_hr),
    .al_day  (al_day),
    .flag    (flag)
  );

  always_comb begin
    day_hi_rd = 8'h00;
    al_hi_rd  = 8'h00;
    day_hi_rd[HI_W-1:0] = day_val[DAY_W-1:8];
    al_hi_rd[HI_W-1:0]  = al_day[DAY_W-1:8];
  end

  always_comb begin
    case (reg_addr)
      ADR_CTL:  reg_rdata = {busy, 1'b0, ctl.den, ctl.hen, ctl.men,
                             flag, ctl.ien, ctl.run};
      ADR_SEC:  reg_rdata = f_val[0];
      ADR_MIN:  reg_rdata = f_val[1];
      ADR_HR:   reg_rdata = f_val[2];
      ADR_DLO:  reg_rdata = day_val[7:0];
      ADR_DHI:  reg_rdata = day_hi_rd;
      ADR_AMIN: reg_rdata = al_min;
      ADR_AHR:  reg_rdata = al_hr;
      ADR_ADLO: reg_rdata = al_day[7:0];
      ADR_ADHI: reg_rdata = al_hi_rd;
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign alarm_irq = flag & ctl.ien;

  // R9: a write seen in a busy cycle is parked for the next cycle
  a_r9_park_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && busy) |=> held_v);

  // R7: seconds stay put while counting is off and nothing is written
  a_r7_stopped_seconds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !app_v) |=> $stable(f_val[0]));

  // R14: interrupt line never high without the sticky flag
  a_r14_irq_from_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> (flag && ctl.ien));

endmodule

// File: tb/bcd_day_calendar_tb.sv
`timescale 1ns/1ps
module bcd_day_calendar_tb;

  localparam logic [7:0] A_CTL  = 8'h14;
  localparam logic [7:0] A_SEC  = 8'h15;
  localparam logic [7:0] A_MIN  = 8'h16;
  localparam logic [7:0] A_HR   = 8'h17;
  localparam logic [7:0] A_DLO  = 8'h18;
  localparam logic [7:0] A_DHI  = 8'h19;
  localparam logic [7:0] A_AMIN = 8'h1A;
  localparam logic [7:0] A_AHR  = 8'h1B;
  localparam logic [7:0] A_ADLO = 8'h1C;
  localparam logic [7:0] A_ADHI = 8'h1D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       alarm_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit req = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  bcd_day_calendar u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .alarm_irq (alarm_irq)
  );

  // monitor: pops expected read values and compares
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (req && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: rdata=0x%02h expected=0x%02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic push_exp(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a; push_exp(e, t); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  // read while a tick is presented in the same cycle
  task automatic rd_tick(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    tick = 1'b1; reg_addr = a; push_exp(e, t); req = 1'b1;
    @(negedge clk);
    tick = 1'b0; req = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    #1;
    n_cmp++;
    if (alarm_irq !== e) begin
      n_bad++;
      $display("FAIL %s: alarm_irq=%0b expected=%0b", t, alarm_irq, e);
    end
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(A_HR, h); wr(A_MIN, m); wr(A_SEC, s);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTL, 8'h00, "R1 ctl");
    rd(A_SEC, 8'h00, "R1 sec");
    rd(A_DHI, 8'h00, "R1 day hi");
    rd(A_AMIN, 8'h00, "R1 alarm min");
    chk_irq(1'b0, "R1 irq");

    // R2 unmapped address
    wr(8'h20, 8'hAA);
    rd(8'h20, 8'h00, "R2 unmapped");
    rd(8'h13, 8'h00, "R2 unmapped 13");

    // R7 tick while stopped
    wr(A_SEC, 8'h10);
    rd_tick(A_CTL, 8'h00, "R7 no busy when stopped");
    rd(A_SEC, 8'h10, "R7 sec unchanged");

    // R8 busy, R4 advance
    wr(A_CTL, 8'h01);
    rd_tick(A_CTL, 8'h81, "R8 busy in tick cycle");
    rd(A_SEC, 8'h11, "R4 sec advance");
    rd(A_CTL, 8'h01, "R8 busy clears, R3 bits");
    wr(A_SEC, 8'h19); pulse();
    rd(A_SEC, 8'h20, "R4 bcd digit carry");

    // R5 minute/hour carry
    set_time(8'h07, 8'h59, 8'h59); pulse();
    rd(A_SEC, 8'h00, "R4 sec wrap");
    rd(A_MIN, 8'h00, "R5 min wrap");
    rd(A_HR, 8'h08, "R5 hour carry");

    // R6 day wrap at full count
    wr(A_DLO, 8'hFF); wr(A_DHI, 8'hFF);
    rd(A_DHI, 8'h7F, "R6 day hi bit7 dropped");
    set_time(8'h23, 8'h59, 8'h59); pulse();
    rd(A_HR, 8'h00, "R5 hour wrap");
    rd(A_DLO, 8'h00, "R6 day lo wrap");
    rd(A_DHI, 8'h00, "R6 day hi wrap");

    // R6 low-to-high byte carry
    wr(A_DLO, 8'hFF);
    set_time(8'h23, 8'h59, 8'h59); pulse();
    rd(A_DLO, 8'h00, "R6 day lo carry");
    rd(A_DHI, 8'h01, "R6 day hi carry");

    // R9 write during busy cycle
    wr(A_SEC, 8'h10);
    @(negedge clk);
    tick = 1'b1; reg_we = 1'b1; reg_addr = A_SEC; reg_wdata = 8'h30;
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    push_exp(8'h11, "R9 write not applied in busy cycle"); req = 1'b1;
    @(negedge clk);
    push_exp(8'h30, "R9 held write applied next cycle");
    @(negedge clk);
    req = 1'b0;

    // R10 minute alarm, R14 irq, R13 clear rules
    set_time(8'h05, 8'h09, 8'h58);
    wr(A_DLO, 8'h03); wr(A_DHI, 8'h00);
    wr(A_AMIN, 8'h10);
    wr(A_CTL, 8'h0B);
    pulse();
    rd(A_CTL, 8'h0B, "R10 no flag before rollover");
    chk_irq(1'b0, "R14 irq low without flag");
    pulse();
    rd(A_CTL, 8'h0F, "R10 flag on minute match");
    chk_irq(1'b1, "R14 irq with flag and enable");
    rd(A_AMIN, 8'h10, "R2 alarm minute readback");
    wr(A_CTL, 8'h0B);
    rd(A_CTL, 8'h0F, "R13 write 0 keeps flag");
    wr(A_CTL, 8'h0F);
    rd(A_CTL, 8'h0B, "R13 write 1 clears flag");
    chk_irq(1'b0, "R14 irq after clear");

    // R12 hour already equal across minute rollover
    wr(A_AHR, 8'h05);
    wr(A_CTL, 8'h13);
    wr(A_SEC, 8'h59); pulse();
    rd(A_MIN, 8'h11, "R12 minute advanced");
    rd(A_CTL, 8'h13, "R12 no repeat while equal");

    // R10 hour match with interrupt disabled, R14 gating
    set_time(8'h04, 8'h59, 8'h59);
    wr(A_CTL, 8'h11);
    pulse();
    rd(A_CTL, 8'h15, "R10 flag on hour match");
    chk_irq(1'b0, "R14 irq masked by enable");
    wr(A_CTL, 8'h13);
    rd(A_CTL, 8'h17, "R13 flag kept on enable write");
    chk_irq(1'b1, "R14 irq after enable");
    wr(A_CTL, 8'h17);
    rd(A_CTL, 8'h13, "R13 cleared");

    // R11 day field enabled and mismatched, minute field disabled
    wr(A_ADLO, 8'h04); wr(A_ADHI, 8'h00);
    set_time(8'h04, 8'h59, 8'h59);
    wr(A_CTL, 8'h33);
    pulse();
    rd(A_CTL, 8'h33, "R11 day mismatch blocks flag");
    chk_irq(1'b0, "R11 irq stays low");
    wr(A_DLO, 8'h04);
    set_time(8'h04, 8'h59, 8'h59);
    pulse();
    rd(A_CTL, 8'h37, "R11 day and hour match, minute ignored");
    chk_irq(1'b1, "R14 irq on day match");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule